// File: doc/BRIEF.md
# Indexed-Window SPI Flash Bridge

This bridge lets a host with a byte-wide I/O bus drive an SPI flash through a 16-bit internal register space. The space is reached through three I/O ports: a bank port holds the high address byte, an offset port holds the low address byte, and a data port reads or writes the register those two bytes select. Three registers at the top of the space run the SPI master. A configuration register holds the chip-select control and the busy flag. A command register starts one byte transfer. A data register returns the byte captured from the flash.

Software opens a transaction by setting the force-low bit. It then writes each outgoing byte to the command register and polls busy until it clears. To read, it writes 0x00 to the command register and fetches the captured byte from the data register. Clearing the force-low bit ends the transaction. The space also holds two read-only identification bytes and a hold bit that keeps an attached processor in reset.

Top module: `spi_window_bridge`

## Requirements
- R1: Port code 1 selects the bank byte, 2 the offset byte and 3 the data window. Bank and offset read back what was written. Port code 0 reads 0x00 and ignores writes.
- R2: The window address is {bank, offset}. An unmapped address reads 0x00, and a write to it changes nothing.
- R3: Address 0xFF00 always reads 0xA2 and address 0xFF24 always reads 0x02. Writes to either leave the value unchanged.
- R4: Bit 0 of address 0xFF14 is read/write and drives `cpu_hold`. The other bits of that register read 0.
- R5: In the configuration register at 0xFEAD, bit 4 is force-low. `spi_cs_n` is low in the cycle after bit 4 is written as 1. It stays low across any number of byte transfers and goes high only when bit 4 is written as 0.
- R6: Configuration bits 3 and 0 are read/write storage. Bits 7:5 and 2 read 0. A write to the command register starts a transfer only while bit 3 is 1.
- R7: A write to the command register at 0xFEAC sends that byte on `spi_mosi` in SPI mode 0, most significant bit first. The transfer has exactly 8 rising SCLK edges. MOSI changes only while SCLK is low, and SCLK half-period is CLK_HALF system clocks.
- R8: Configuration bit 1 (busy) reads 1 from the cycle after a transfer starts until the transfer completes. It then reads 0.
- R9: `spi_miso` is sampled on each rising SCLK edge, most significant bit first. After busy clears, address 0xFEAB returns the captured byte. Writing 0x00 to the command register clocks in a byte this way.
- R10: A command-register write while busy is 1 is ignored. The byte in flight finishes unchanged and no further byte is sent.
- R11: SCLK idles low. Writes to the SPI data register at 0xFEAB do not change the value it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_port | input | 2 | Window port select: 0 none, 1 bank, 2 offset, 3 data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte for the selected port, combinational |
| cpu_hold | output | 1 | Processor reset-hold bit |
| spi_cs_n | output | 1 | Active-low flash chip select |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions assume that `io_wr` is a single-cycle strobe, that `io_port` and `io_wdata` are stable while the strobe is high, and that `spi_miso` does not change at a rising SCLK edge. They also assume software does not clear force-low while a byte is in flight.

The bench drives every bus access at the falling clock edge and holds it for one full cycle. Its flash responder changes MISO only on falling SCLK. The bench waits for busy to clear by polling before it ends a transaction. The one deliberate exception is a command write issued while busy, which checks that the write is dropped.

// File: rtl/swb_pkg.sv
package swb_pkg;
    localparam logic [15:0] A_SPI_DATA = 16'hFEAB;
    localparam logic [15:0] A_SPI_CMD  = 16'hFEAC;
    localparam logic [15:0] A_SPI_CFG  = 16'hFEAD;
    localparam logic [15:0] A_ID_HW    = 16'hFF00;
    localparam logic [15:0] A_ID_IF    = 16'hFF24;
    localparam logic [15:0] A_HOLD     = 16'hFF14;
    localparam logic [7:0]  ID_HW_VAL  = 8'hA2;
    localparam logic [7:0]  ID_IF_VAL  = 8'h02;

    localparam int CFG_FORCE = 4;
    localparam int CFG_WEN   = 3;
    localparam int CFG_BUSY  = 1;
    localparam int CFG_CHK   = 0;

    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_BANK = 2'd1,
        PORT_OFFS = 2'd2,
        PORT_DATA = 2'd3
    } port_e;
endpackage

// File: rtl/swb_regs.sv
module swb_regs
    import swb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] io_port,
    input  logic       io_wr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic       busy,
    input  logic [7:0] rx_byte,
    output logic       start,
    output logic [7:0] start_byte,
    output logic       cs_n,
    output logic       cpu_hold
);
    typedef struct packed {
        logic [7:0] bank;
        logic [7:0] offs;
        logic       force_lo;
        logic       wr_en;
        logic       chk_en;
        logic       hold;
    } regs_t;

    regs_t s_d, s_q;
    logic [15:0] addr;
    logic        data_wr;
    logic [7:0]  cfg_rd;

    assign addr    = {s_q.bank, s_q.offs};
    assign data_wr = io_wr && (port_e'(io_port) == PORT_DATA);
    assign cfg_rd  = {3'b000, s_q.force_lo, s_q.wr_en, 1'b0, busy, s_q.chk_en};

    always_comb begin
        s_d        = s_q;
        start      = 1'b0;
        start_byte = io_wdata;
        if (io_wr && port_e'(io_port) == PORT_BANK) s_d.bank = io_wdata;
        if (io_wr && port_e'(io_port) == PORT_OFFS) s_d.offs = io_wdata;
        if (data_wr) begin
            unique case (addr)
                A_SPI_CFG: begin
                    s_d.force_lo = io_wdata[CFG_FORCE];
                    s_d.wr_en    = io_wdata[CFG_WEN];
                    s_d.chk_en   = io_wdata[CFG_CHK];
                end
                A_SPI_CMD: start = s_q.wr_en && !busy;
                A_HOLD:    s_d.hold = io_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        io_rdata = 8'h00;
        unique case (port_e'(io_port))
            PORT_BANK: io_rdata = s_q.bank;
            PORT_OFFS: io_rdata = s_q.offs;
            PORT_DATA: begin
                unique case (addr)
                    A_SPI_DATA: io_rdata = rx_byte;
                    A_SPI_CFG:  io_rdata = cfg_rd;
                    A_ID_HW:    io_rdata = ID_HW_VAL;
                    A_ID_IF:    io_rdata = ID_IF_VAL;
                    A_HOLD:     io_rdata = {7'd0, s_q.hold};
                    default:    io_rdata = 8'h00;
                endcase
            end
            default: io_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cs_n     = !s_q.force_lo;
    assign cpu_hold = s_q.hold;

    AST_CS_ON_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && addr == A_SPI_CFG && io_wdata[CFG_FORCE]) |=> !cs_n); // R5
    AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (port_e'(io_port) == PORT_DATA && addr == A_ID_HW) |-> io_rdata == ID_HW_VAL); // R3
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && addr == A_HOLD) |=> $stable(cpu_hold)); // R4
endmodule

// File: rtl/swb_shifter.sv
module swb_shifter #(
    parameter int CLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] start_byte,
    input  logic       miso,
    output logic       busy,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte
);
    localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_HALF - 1);

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic [DW-1:0] div;
        logic [2:0]    bitn;
        logic [7:0]    tx;
        logic [7:0]    rx;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.sclk = 1'b0;
            s_d.div  = '0;
            s_d.bitn = '0;
            s_d.tx   = start_byte;
        end else if (s_q.busy) begin
            if (s_q.div == DIV_LAST) begin
                s_d.div  = '0;
                s_d.sclk = !s_q.sclk;
                if (!s_q.sclk) begin
                    s_d.rx = {s_q.rx[6:0], miso};
                end else begin
                    s_d.tx = {s_q.tx[6:0], 1'b0};
                    if (s_q.bitn == 3'd7) s_d.busy = 1'b0;
                    else                  s_d.bitn = s_q.bitn + 3'd1;
                end
            end else begin
                s_d.div = s_q.div + DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign sclk    = s_q.sclk;
    assign mosi    = s_q.tx[7];
    assign rx_byte = s_q.rx;

    logic [3:0] chk_rises;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      chk_rises <= '0;
        else if (start && !s_q.busy)     chk_rises <= '0;
        else if (s_d.sclk && !s_q.sclk)  chk_rises <= chk_rises + 4'd1;
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R10
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk); // R11
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi)); // R7
    AST_EIGHT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> chk_rises == 4'd8); // R7
endmodule

// File: rtl/spi_window_bridge.sv
module spi_window_bridge #(
    parameter int CLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] io_port,
    input  logic       io_wr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output logic       cpu_hold,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic       busy;
    logic       start;
    logic [7:0] start_byte;
    logic [7:0] rx_byte;

    swb_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_port    (io_port),
        .io_wr      (io_wr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .busy       (busy),
        .rx_byte    (rx_byte),
        .start      (start),
        .start_byte (start_byte),
        .cs_n       (spi_cs_n),
        .cpu_hold   (cpu_hold)
    );

    swb_shifter #(.CLK_HALF(CLK_HALF)) i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_byte (start_byte),
        .miso       (spi_miso),
        .busy       (busy),
        .sclk       (spi_sclk),
        .mosi       (spi_mosi),
        .rx_byte    (rx_byte)
    );
endmodule

// File: tb/test_spi_window_bridge.sv
`timescale 1ns/100ps
module test_spi_window_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] io_port = 2'd0;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       cpu_hold, spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    int tests = 0;
    int fails = 0;

    spi_window_bridge #(.CLK_HALF(2)) i_spi_window_bridge (
        .clk(clk), .rst_n(rst_n), .io_port(io_port), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_hold(cpu_hold),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Scoreboard of bytes the flash should see on MOSI
    logic [7:0] exp_q[$];
    int got_bytes = 0;
    int rises = 0;

    // Flash responder and monitor
    logic       prev_cs = 1'b1, prev_sclk = 1'b0;
    int         cnt = 0;
    logic [7:0] rxs = 8'h00, resp = 8'h00;
    always begin
        @(spi_cs_n or spi_sclk);
        if (prev_cs && !spi_cs_n) begin
            cnt = 0; resp = 8'h5A; spi_miso = resp[7];
        end else if (!spi_cs_n && !prev_sclk && spi_sclk) begin
            rxs = {rxs[6:0], spi_mosi}; cnt++; rises++;
        end else if (!spi_cs_n && prev_sclk && !spi_sclk) begin
            if (cnt == 8) begin
                got_bytes++;
                if (exp_q.size() == 0) chk("R10 unexpected MOSI byte", rxs, 8'hxx);
                else chk("R7 MOSI byte", rxs, exp_q.pop_front());
                resp = ~rxs; cnt = 0; spi_miso = resp[7];
            end else spi_miso = resp[7 - cnt];
        end
        prev_cs = spi_cs_n; prev_sclk = spi_sclk;
    end

    task automatic wr(input logic [1:0] p, input logic [7:0] d);
        @(negedge clk); io_port = p; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] p, output logic [7:0] v);
        @(negedge clk); io_port = p; io_wr = 1'b0; #1; v = io_rdata;
    endtask

    task automatic sel(input logic [15:0] a);
        wr(2'd1, a[15:8]); wr(2'd2, a[7:0]);
    endtask

    task automatic rreg(input logic [15:0] a, output logic [7:0] v);
        sel(a); rd(2'd3, v);
    endtask

    task automatic wreg(input logic [15:0] a, input logic [7:0] d);
        sel(a); wr(2'd3, d);
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        sel(16'hFEAD);
        for (int i = 0; i < 200; i++) begin
            rd(2'd3, v);
            if (!v[1]) break;
        end
        chk("R8 busy clears", {7'd0, v[1]}, 8'h00);
    endtask

    // Driver: queue the expected MOSI byte and start the transfer
    task automatic send(input logic [7:0] b);
        logic [7:0] v;
        exp_q.push_back(b);
        wreg(16'hFEAC, b);
        sel(16'hFEAD); rd(2'd3, v);
        chk("R8 busy set after command", {7'd0, v[1]}, 8'h01);
        wait_idle();
    endtask

    initial begin
        #(200000 * 5);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int r0, b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R5 reset cs_n high", {7'd0, spi_cs_n}, 8'h01);
        chk("R11 reset sclk low", {7'd0, spi_sclk}, 8'h00);
        chk("R4 reset hold low", {7'd0, cpu_hold}, 8'h00);
        rd(2'd0, v); chk("R1 port 0 reads zero", v, 8'h00);

        sel(16'hFF00);
        rd(2'd1, v); chk("R1 bank readback", v, 8'hFF);
        rd(2'd2, v); chk("R1 offset readback", v, 8'h00);
        rd(2'd3, v); chk("R3 id A2", v, 8'hA2);
        wr(2'd3, 8'h55); rd(2'd3, v); chk("R3 id write ignored", v, 8'hA2);
        rreg(16'hFF24, v); chk("R3 id 02", v, 8'h02);
        wreg(16'hFF01, 8'h99); rd(2'd3, v); chk("R2 unmapped reads zero", v, 8'h00);
        wr(2'd0, 8'h12); rd(2'd1, v); chk("R1 port 0 write ignored", v, 8'hFF);

        wreg(16'hFF14, 8'h01); rd(2'd3, v); chk("R4 hold read", v, 8'h01);
        chk("R4 hold pin", {7'd0, cpu_hold}, 8'h01);
        wr(2'd3, 8'hFE); rd(2'd3, v); chk("R4 hold clear, upper bits zero", v, 8'h00);
        chk("R4 hold pin low", {7'd0, cpu_hold}, 8'h00);

        wreg(16'hFEAD, 8'hFF); rd(2'd3, v); chk("R6 cfg stored bits", v, 8'h19);
        chk("R5 cs asserted", {7'd0, spi_cs_n}, 8'h00);

        r0 = rises;
        send(8'h9F);
        chk("R7 eight SCLK rises", 8'(rises - r0), 8'd8);
        rreg(16'hFEAB, v); chk("R9 first captured byte", v, 8'h5A);
        chk("R5 cs held after byte", {7'd0, spi_cs_n}, 8'h00);
        send(8'h00);
        rreg(16'hFEAB, v); chk("R9 read byte via 0x00 write", v, 8'h60);
        wr(2'd3, 8'h77); rd(2'd3, v); chk("R11 data register write ignored", v, 8'h60);
        chk("R11 sclk idle low", {7'd0, spi_sclk}, 8'h00);

        b0 = got_bytes;
        exp_q.push_back(8'hA5);
        sel(16'hFEAC);
        wr(2'd3, 8'hA5);
        wr(2'd3, 8'h3C);
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R10 only one byte sent", 8'(got_bytes - b0), 8'd1);
        rreg(16'hFEAB, v); chk("R10 captured byte of first command", v, 8'hFF);

        wreg(16'hFEAD, 8'h10);
        b0 = got_bytes;
        wreg(16'hFEAC, 8'h11);
        sel(16'hFEAD); rd(2'd3, v);
        chk("R6 write-enable clear blocks start", v, 8'h10);
        repeat (40) @(negedge clk);
        chk("R6 no byte sent", 8'(got_bytes - b0), 8'd0);

        wreg(16'hFEAD, 8'h00);
        chk("R5 cs released", {7'd0, spi_cs_n}, 8'h01);
        chk("R7 scoreboard drained", 8'(exp_q.size()), 8'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule